// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Shared Interrupt

This block holds several banks of general-purpose I/O lines. Each bank has up to 32 lines and its own set of eight 32-bit control registers, reached through a simple synchronous register port. For every line, software picks a direction, an output value and an open-drain behaviour. The block drives an output-enable and an output value to each pad and samples each input pin through a two-flop synchronizer.

Every line can also raise an event. A line can be level-sensitive (active high or active low) or edge-sensitive (rising, falling or both). Events latch into a per-bank status register that is cleared by writing ones. Each bank's status is ANDed with its mask register, and one interrupt output is asserted whenever any bank has a pending, unmasked event. A bank may be built narrower than 32 lines. Its unused bits then behave as absent.

Top module: `gpb_top`

## Requirements
- R1: The register port uses word addresses. Bits [2:0] select the register within a bank, and the bits above select the bank, so bank n starts at word n*8 (byte n*32). Register indices are: 0 open-drain enable, 1 data, 2 direction, 3 edge config, 4 both-edge select, 5 mask, 6 level select, 7 status. A write takes effect at the clock edge where it is presented. Read data appears on `bus_rdata` after the clock edge where the read is presented and holds until the next read.
- R2: After reset:
  - every direction bit inside the bank width reads 1 (input);
  - all other registers read 0;
  - `irq_out` is low;
  - every `pad_oe` bit is low.
- R3: A direction bit of 0 makes that line an output, with `pad_oe`=1 and `pad_out` equal to the data bit. A direction bit of 1 makes it an input with `pad_oe`=0. Reading the data register returns the synchronized pin value for input lines and the stored data bit for output lines.
- R4: On an output line whose open-drain bit is 1, a data bit of 0 drives the pad low (`pad_oe`=1, `pad_out`=0), and a data bit of 1 releases it (`pad_oe`=0).
- R5: With level select 1, the line is level-sensitive: edge config 1 means active high and 0 means active low. The status bit is set again on every cycle in which the level stays active.
- R6: With level select 0 and both-edge select 0, edge config 1 latches rising edges and edge config 0 latches falling edges. Edges are found by comparing successive synchronized samples.
- R7: With level select 0 and both-edge select 1, both edges latch, whatever the edge config bit is.
- R8: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If a new event arrives in the same cycle as a clearing write, the event wins and the bit stays set.
- R9: `irq_out` is high exactly when, for some bank, status AND mask is nonzero. Status keeps its latched events while the mask is 0, so unmasking an already-latched event raises `irq_out`.
- R10: In a bank built with width W < 32, register bits at W and above read 0, never set in status, and keep their `pad_oe` low.
- R11: A pin change that triggers an edge event sets its status bit on the third rising clock edge after the change: two synchronizer stages, then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BANK_IDX_W+3 | Word address: {bank, register index} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | NUM_BANKS*32 | Raw input pins, 32 per bank |
| pad_out | output | NUM_BANKS*32 | Output values to the pads |
| pad_oe | output | NUM_BANKS*32 | Output enables to the pads |
| irq_out | output | 1 | Shared interrupt, any bank pending |

## Verification
The hardest case to reach from the ports is a clearing write that lands while a level event is still active, so that the new event must win over the clear. The bench sweeps a pin pattern over a bank in which consecutive lines cycle through all five trigger types. Before each pattern change, it clears the whole status word while the pins are held steady. For level lines that are still active, that clear coincides with a fresh event. The expected status is then computed arithmetically:

expected = edges(old pins → new pins) | active_level(old pins) | active_level(new pins)

The exact three-edge latency is checked by watching `irq_out` edge by edge after a single pin change.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int LINE_MAX  = 32;
    localparam int REG_IDX_W = 3;

    typedef enum logic [REG_IDX_W-1:0] {
        RG_ODRAIN   = 3'd0,
        RG_DATA     = 3'd1,
        RG_DIR      = 3'd2,
        RG_EDGECFG  = 3'd3,
        RG_BOTHEDGE = 3'd4,
        RG_MASK     = 3'd5,
        RG_LEVEL    = 3'd6,
        RG_STATUS   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [LINE_MAX-1:0] odrain;
        logic [LINE_MAX-1:0] data;
        logic [LINE_MAX-1:0] dir;
        logic [LINE_MAX-1:0] edgecfg;
        logic [LINE_MAX-1:0] bothedge;
        logic [LINE_MAX-1:0] mask;
        logic [LINE_MAX-1:0] level;
        logic [LINE_MAX-1:0] status;
    } bank_regs_t;

    typedef struct packed {
        logic                wr;
        reg_sel_e            sel;
        logic [LINE_MAX-1:0] wdata;
    } bank_req_t;

    function automatic logic [LINE_MAX-1:0] width_mask(input int unsigned w);
        logic [LINE_MAX-1:0] m;
        for (int i = 0; i < LINE_MAX; i++) m[i] = (i < w);
        return m;
    endfunction

    // Per-line event detection from the trigger configuration and two samples
    function automatic logic [LINE_MAX-1:0] detect_events(
        input logic [LINE_MAX-1:0] level,
        input logic [LINE_MAX-1:0] edgecfg,
        input logic [LINE_MAX-1:0] bothedge,
        input logic [LINE_MAX-1:0] cur,
        input logic [LINE_MAX-1:0] prev
    );
        logic [LINE_MAX-1:0] lvl_hit, rise, fall, one_edge, edge_hit;
        lvl_hit  = (edgecfg & cur) | (~edgecfg & ~cur);
        rise     = cur & ~prev;
        fall     = ~cur & prev;
        one_edge = (edgecfg & rise) | (~edgecfg & fall);
        edge_hit = (bothedge & (rise | fall)) | (~bothedge & one_edge);
        return (level & lvl_hit) | (~level & edge_hit);
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/gpb_pad_drive.sv
module gpb_pad_drive
    import gpb_pkg::*;
#(
    parameter int WIDTH = LINE_MAX
) (
    input  logic [LINE_MAX-1:0] dir,
    input  logic [LINE_MAX-1:0] odrain,
    input  logic [LINE_MAX-1:0] data,
    output logic [LINE_MAX-1:0] oe,
    output logic [LINE_MAX-1:0] out
);
    localparam logic [LINE_MAX-1:0] WMASK = width_mask(WIDTH);

    logic [LINE_MAX-1:0] is_out;
    logic [LINE_MAX-1:0] released;

    always_comb begin
        is_out   = ~dir & WMASK;
        // open-drain line with data 1 floats
        released = odrain & data;
        oe       = is_out & ~released;
        out      = is_out & data & ~odrain;
    end
endmodule

// File: rtl/gpb_bank.sv
module gpb_bank
    import gpb_pkg::*;
#(
    parameter int WIDTH = LINE_MAX
) (
    input  logic                clk,
    input  logic                rst,
    input  bank_req_t           req,
    input  logic [LINE_MAX-1:0] pins_in,
    output logic [LINE_MAX-1:0] pins_out,
    output logic [LINE_MAX-1:0] pins_oe,
    output logic [LINE_MAX-1:0] rd_word,
    output logic [LINE_MAX-1:0] pending
);
    localparam logic [LINE_MAX-1:0] WMASK = width_mask(WIDTH);

    bank_regs_t          r;
    logic [LINE_MAX-1:0] cur_smp;
    logic [LINE_MAX-1:0] prev_smp;
    logic [LINE_MAX-1:0] hit;
    logic [LINE_MAX-1:0] clr;
    logic [LINE_MAX-1:0] wval;
    logic                stat_wr;

    gpb_sync #(.W(LINE_MAX)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pins_in),
        .q_sync  (cur_smp)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_smp <= '0;
        else     prev_smp <= cur_smp;
    end

    always_comb begin
        hit     = detect_events(r.level, r.edgecfg, r.bothedge, cur_smp, prev_smp) & WMASK;
        wval    = req.wdata & WMASK;
        stat_wr = req.wr && (req.sel == RG_STATUS);
        clr     = stat_wr ? wval : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r.odrain   <= '0;
            r.data     <= '0;
            r.dir      <= WMASK;
            r.edgecfg  <= '0;
            r.bothedge <= '0;
            r.mask     <= '0;
            r.level    <= '0;
            r.status   <= '0;
        end else begin
            if (req.wr) begin
                case (req.sel)
                    RG_ODRAIN:   r.odrain   <= wval;
                    RG_DATA:     r.data     <= wval;
                    RG_DIR:      r.dir      <= wval;
                    RG_EDGECFG:  r.edgecfg  <= wval;
                    RG_BOTHEDGE: r.bothedge <= wval;
                    RG_MASK:     r.mask     <= wval;
                    RG_LEVEL:    r.level    <= wval;
                    default:     ;
                endcase
            end
            // a fresh event overrides a simultaneous clear
            r.status <= ((r.status & ~clr) | hit) & WMASK;
        end
    end

    always_comb begin
        case (req.sel)
            RG_ODRAIN:   rd_word = r.odrain;
            RG_DATA:     rd_word = ((r.dir & cur_smp) | (~r.dir & r.data)) & WMASK;
            RG_DIR:      rd_word = r.dir;
            RG_EDGECFG:  rd_word = r.edgecfg;
            RG_BOTHEDGE: rd_word = r.bothedge;
            RG_MASK:     rd_word = r.mask;
            RG_LEVEL:    rd_word = r.level;
            default:     rd_word = r.status;
        endcase
    end

    assign pending = r.status & r.mask;

    gpb_pad_drive #(.WIDTH(WIDTH)) u_pad (
        .dir    (r.dir),
        .odrain (r.odrain),
        .data   (r.data),
        .oe     (pins_oe),
        .out    (pins_out)
    );

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && ((wval & ~hit) != '0)) |=> ((r.status & $past(wval & ~hit)) == '0));

    // R6
    status_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((r.status & ~$past(r.status) & ~$past(hit)) == '0));

    // R9
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> (($past(r.status) & ~r.status) == '0));

endmodule

// File: rtl/gpb_top.sv
module gpb_top
    import gpb_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd20, 6'd32},
    parameter int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_sel,
    input  logic                          bus_wr,
    input  logic [BANK_IDX_W+REG_IDX_W-1:0] bus_addr,
    input  logic [LINE_MAX-1:0]           bus_wdata,
    output logic [LINE_MAX-1:0]           bus_rdata,
    input  logic [NUM_BANKS*LINE_MAX-1:0] pad_in,
    output logic [NUM_BANKS*LINE_MAX-1:0] pad_out,
    output logic [NUM_BANKS*LINE_MAX-1:0] pad_oe,
    output logic                          irq_out
);
    localparam int SLOTS = 1 << BANK_IDX_W;

    logic [BANK_IDX_W-1:0] bank_idx;
    reg_sel_e              reg_idx;
    logic [LINE_MAX-1:0]   rd_words [SLOTS];
    logic [NUM_BANKS-1:0]  bank_pend;

    assign bank_idx = bus_addr[BANK_IDX_W+REG_IDX_W-1:REG_IDX_W];
    assign reg_idx  = reg_sel_e'(bus_addr[REG_IDX_W-1:0]);

    for (genvar b = 0; b < SLOTS; b++) begin : g_bank
        if (b < NUM_BANKS) begin : g_real
            localparam int BW = int'(BANK_WIDTHS[b*6 +: 6]);
            bank_req_t           req;
            logic [LINE_MAX-1:0] pend;

            always_comb begin
                req.wr    = bus_sel && bus_wr && (bank_idx == BANK_IDX_W'(b));
                req.sel   = reg_idx;
                req.wdata = bus_wdata;
            end

            gpb_bank #(.WIDTH(BW)) u_bank (
                .clk      (clk),
                .rst      (rst),
                .req      (req),
                .pins_in  (pad_in[b*LINE_MAX +: LINE_MAX]),
                .pins_out (pad_out[b*LINE_MAX +: LINE_MAX]),
                .pins_oe  (pad_oe[b*LINE_MAX +: LINE_MAX]),
                .rd_word  (rd_words[b]),
                .pending  (pend)
            );

            assign bank_pend[b] = |pend;
        end else begin : g_hole
            assign rd_words[b] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_words[bank_idx];
    end

    assign irq_out = |bank_pend;

    // R9
    irq_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_out) |-> $past(bus_sel && bus_wr));

    // R1
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_sel && !bus_wr) |-> $stable(bus_rdata));

endmodule

// File: tb/gpb_top_bench.sv
module gpb_top_bench;
    import gpb_pkg::*;

    localparam int NB = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [63:0]   pad_in = '0;
    logic [63:0]   pad_out;
    logic [63:0]   pad_oe;
    logic          irq_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #5 clk = ~clk;

    gpb_top #(.NUM_BANKS(NB), .BANK_WIDTHS({6'd20, 6'd32})) u_gpb_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int bank, input int rg, input logic [31:0] val);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = 4'((bank << 3) | rg); bus_wdata = val;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int bank, input int rg, output logic [31:0] val);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0;
        bus_addr = 4'((bank << 3) | rg);
        @(negedge clk);
        bus_sel = 1'b0;
        val = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // trigger type of bank-0 line i: 0 lvl-low, 1 lvl-high, 2 fall, 3 rise, 4 both
    function automatic int ttype(input int i);
        return i % 5;
    endfunction

    function automatic logic [31:0] exp_events(input logic [31:0] o, input logic [31:0] n);
        logic [31:0] e;
        for (int i = 0; i < 32; i++) begin
            case (ttype(i))
                0: e[i] = !o[i] || !n[i];
                1: e[i] = o[i] || n[i];
                2: e[i] = o[i] && !n[i];
                3: e[i] = !o[i] && n[i];
                default: e[i] = o[i] != n[i];
            endcase
        end
        return e;
    endfunction

    initial begin
        logic [31:0] v;
        logic [31:0] lvl, ec, be, prev_p, nxt;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R2 reset state
        rd(0, 2, v); check("R2 bank0 dir", v, 32'hFFFF_FFFF);
        rd(1, 2, v); check("R2 bank1 dir", v, 32'h000F_FFFF);
        rd(0, 7, v); check("R2 status", v, 0);
        rd(1, 5, v); check("R2 mask", v, 0);
        check("R2 irq", irq_out, 0);
        check("R2 oe", pad_oe, 0);

        // R1 register map
        wr(0, 5, 32'h1234_5678);
        wr(1, 3, 32'h000A_BCDE);
        rd(0, 5, v); check("R1 bank0 mask", v, 32'h1234_5678);
        rd(1, 3, v); check("R1 bank1 edgecfg", v, 32'h000A_BCDE);
        rd(0, 3, v); check("R1 bank0 edgecfg untouched", v, 0);
        rd(1, 5, v); check("R1 bank1 mask untouched", v, 0);
        idle(2);
        check("R1 rdata holds", bus_rdata, 0);
        wr(0, 5, 0); wr(1, 3, 0);

        // R3 direction and data
        wr(1, 1, 32'h0000_00A5);
        wr(1, 2, 32'hFFFF_FF00);
        idle(1);
        check("R3 oe low byte", pad_oe[39:32], 8'hFF);
        check("R3 out low byte", pad_out[39:32], 8'hA5);
        check("R3 oe input lines", pad_oe[51:40], 0);
        pad_in[40] = 1'b1;
        idle(3);
        rd(1, 1, v); check("R3 data read mix", v, 32'h0000_01A5);

        // R4 open drain on bank1 line 0 (data bit 0 currently 1)
        wr(1, 0, 32'h1);
        idle(1);
        check("R4 released", pad_oe[32], 0);
        wr(1, 1, 32'h0000_00A4);
        idle(1);
        check("R4 drives low oe", pad_oe[32], 1);
        check("R4 drives low out", pad_out[32], 0);
        wr(1, 0, 0);

        // R10 width limits in bank1
        wr(1, 6, 32'hFFFF_FFFF);
        rd(1, 6, v); check("R10 level readback", v, 32'h000F_FFFF);
        wr(1, 6, 0);
        wr(1, 4, 32'hFFFF_FFFF);
        wr(1, 2, 32'h0);
        idle(1);
        check("R10 oe above width", pad_oe[63:52], 0);
        wr(1, 2, 32'hFFFF_FFFF);
        wr(1, 7, 32'hFFFF_FFFF);
        pad_in[63:52] = 12'hFFF;
        idle(5);
        pad_in[63:52] = 12'h000;
        idle(5);
        rd(1, 7, v); check("R10 status above width", v, 0);
        wr(1, 4, 0);

        // R5 R6 R7 R8 sweep on bank0
        lvl = '0; ec = '0; be = '0;
        for (int i = 0; i < 32; i++) begin
            case (ttype(i))
                0: lvl[i] = 1'b1;
                1: begin lvl[i] = 1'b1; ec[i] = 1'b1; end
                2: ;
                3: ec[i] = 1'b1;
                default: begin be[i] = 1'b1; ec[i] = i[0]; end
            endcase
        end
        wr(0, 6, lvl); wr(0, 3, ec); wr(0, 4, be);
        prev_p = pad_in[31:0];
        idle(4);
        for (int s = 0; s < 20; s++) begin
            case (s)
                0: nxt = 32'hFFFF_FFFF;
                1: nxt = 32'h0;
                default: nxt = (32'(s) * 32'h9E37_79B9) ^ (prev_p >> 3);
            endcase
            wr(0, 7, 32'hFFFF_FFFF);
            @(negedge clk);
            pad_in[31:0] = nxt;
            idle(5);
            rd(0, 7, v);
            check("R5 R6 R7 R8 sweep status", v, exp_events(prev_p, nxt));
            prev_p = nxt;
        end

        // R8 writing zero leaves status
        rd(0, 7, v);
        wr(0, 7, 0);
        begin
            logic [31:0] v2;
            rd(0, 7, v2); check("R8 zero write no effect", v2, v);
        end
        wr(0, 6, 0); wr(0, 3, 0); wr(0, 4, 0);
        wr(0, 7, 32'hFFFF_FFFF);

        // R9 mask and retained status (bank1 line 3 rising)
        wr(1, 3, 32'h18);
        wr(1, 7, 32'hFFFF_FFFF);
        idle(1);
        check("R9 irq idle", irq_out, 0);
        pad_in[35] = 1'b1;
        idle(5);
        check("R9 irq masked", irq_out, 0);
        rd(1, 7, v); check("R9 status kept while masked", v, 32'h8);
        wr(1, 5, 32'h8);
        check("R9 irq on unmask", irq_out, 1);
        wr(1, 7, 32'h8);
        check("R9 irq after clear", irq_out, 0);

        // R11 latency on bank1 line 4 rising, unmasked
        wr(1, 5, 32'h10);
        @(negedge clk);
        pad_in[36] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R11 not yet after two edges", irq_out, 0);
        @(negedge clk);
        check("R11 set on third edge", irq_out, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule